// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between an on-chip requester and an external asynchronous static RAM that holds 131,072 bytes. A requester offers one byte-wide read or write at a time on a valid/ready port. The controller then produces the pin sequence the memory needs: a 17-bit address, a pair of chip selects with opposite polarity, an active-low write strobe, an active-low output enable, and a bidirectional data bus. The bus is split into an outgoing byte, a driver enable and an incoming byte.

Every memory timing limit is given in nanoseconds, together with the clock period. The controller rounds each limit up to whole clocks, so a slower memory speed grade needs only new parameter values. A read result is returned with a one-cycle valid pulse. After every read the controller leaves a turnaround gap, so that its own bus driver never overlaps the memory's output.

Top module: `sram_port_ctrl`

## Requirements
- R1: While reset is low, and after it is released, the select pair is inactive (`mem_sel_n`=1, `mem_sel`=0). In the same state `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `rdata_valid`=0, and `req_ready`=1 once reset is released.
- R2: The memory is selected only as the pair `mem_sel_n`=0 with `mem_sel`=1. The two pins always carry opposite values. Outside read cycles and write-pulse cycles the pair is inactive.
- R3: A write holds `mem_we_n` low for PULSE = max(ceil(T_WP_NS/T_CLK_NS), ceil(T_DS_NS/T_CLK_NS)) cycles. The first of these cycles follows the accepting clock edge. Throughout, the chip is selected, `mem_dq_oe`=1, `mem_dq_out` equals the request byte and `mem_oe_n`=1.
- R4: After the write pulse, the controller keeps driving the data for REC = max(1, ceil(T_WC_NS/T_CLK_NS) − PULSE) cycles, with the chip deselected. `req_ready` returns high exactly PULSE+REC cycles after acceptance, and `mem_dq_oe` is low from that cycle on.
- R5: A read holds `mem_oe_n`=0 for RD = ceil(T_AA_NS/T_CLK_NS) cycles. Throughout, the chip is selected, `mem_we_n`=1 and `mem_dq_oe`=0.
- R6: The byte on `mem_dq_in` is captured at the clock edge that ends the last read cycle. It appears on `rdata` with `rdata_valid` high for exactly the one following cycle, and `rdata` keeps that value afterwards.
- R7: After a read, `mem_oe_n` stays high and `req_ready` stays low for HZ = max(1, ceil(T_HZ_NS/T_CLK_NS)) cycles before the controller accepts again. The driver is never enabled while the memory may still drive the bus.
- R8: `req_ready` is high only when the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Request inputs that change while the controller is busy have no effect on the pins.
- R9: `mem_addr` carries the full 17-bit request address, including 0x00000 and 0x1FFFF. Address and write data stay stable throughout a write pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rdata | output | 8 | Last byte read |
| rdata_valid | output | 1 | One-cycle pulse when `rdata` is new |
| mem_addr | output | 17 | Memory address pins |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | Controller bus driver enable |
| mem_dq_in | input | 8 | Byte received from the data bus |

## Verification
The main path is tried with the byte patterns 0x00, 0xFF, 0xA5 and 0x5A, at the lowest address, the highest address and two alternating-bit addresses. These show whether every data line and every address line reaches the memory unswapped and unstuck. An overwrite followed by a read of the same location separates a real store from stale data. A write issued right after a read checks the turnaround gap. Scrambling the request inputs during each access shows that a busy controller ignores them.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and helper functions for the static RAM access controller.
// Assumes all timing values are positive integers in nanoseconds.
package sram_ctrl_pkg;

    // One-hot sequencer states; each pin decodes from a single state bit.
    typedef enum logic [4:0] {
        ST_IDLE   = 5'b00001,
        ST_READ   = 5'b00010,
        ST_WPULSE = 5'b00100,
        ST_WREC   = 5'b01000,
        ST_TURN   = 5'b10000
    } seq_state_e;

    // Integer division rounded up.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
// Access sequencer: accepts one request when idle and steps through the
// read, write-pulse, write-recovery and turnaround phases. Each phase
// lasts a cycle count fixed at elaboration. Assumes every count is at least 1.
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int RD_CYC    = 2,
    parameter int PULSE_CYC = 2,
    parameter int REC_CYC   = 1,
    parameter int HZ_CYC    = 1,
    parameter int CNT_W     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    output seq_state_e state_d,
    output logic       req_ready,
    output logic       accept,
    output logic       cap_strobe
);

    localparam logic [CNT_W-1:0] RD_LOAD    = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_LOAD = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] REC_LOAD   = CNT_W'(REC_CYC - 1);
    localparam logic [CNT_W-1:0] HZ_LOAD    = CNT_W'(HZ_CYC - 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             last;

    assign last       = (cnt_q == '0);
    assign req_ready  = (state_q == ST_IDLE);
    assign accept     = req_valid && req_ready;
    assign cap_strobe = (state_q == ST_READ) && last;

    // Next-state and phase-counter selection.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_write) begin
                        state_d = ST_WPULSE;
                        cnt_d   = PULSE_LOAD;
                    end else begin
                        state_d = ST_READ;
                        cnt_d   = RD_LOAD;
                    end
                end
            end
            ST_READ: begin
                if (last) begin
                    state_d = ST_TURN;
                    cnt_d   = HZ_LOAD;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_WPULSE: begin
                if (last) begin
                    state_d = ST_WREC;
                    cnt_d   = REC_LOAD;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_WREC, ST_TURN: begin
                if (last) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

endmodule

// File: rtl/sram_pin_drive.sv
// Pin register stage: every memory control pin is a flop loaded from the
// sequencer's next state, so the pins change only at clock edges and do not
// glitch. Address and write byte are latched when a request is accepted.
module sram_pin_drive
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_e        state_d,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_dq_oe
);

    logic sel_d;

    assign sel_d = (state_d == ST_READ) || (state_d == ST_WPULSE);

    // Request latch: address and write byte held for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    // Control pin registers decoded from the upcoming state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_sel_n <= 1'b1;
            mem_sel   <= 1'b0;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_sel_n <= !sel_d;
            mem_sel   <= sel_d;
            mem_we_n  <= !(state_d == ST_WPULSE);
            mem_oe_n  <= !(state_d == ST_READ);
            mem_dq_oe <= (state_d == ST_WPULSE) || (state_d == ST_WREC);
        end
    end

endmodule

// File: rtl/sram_rd_capture.sv
// Read capture: samples the incoming bus byte when the sequencer flags the
// last read cycle, and raises a one-cycle valid pulse with it.
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_strobe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid
);

    // Data register, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (cap_strobe) begin
            rdata <= mem_dq_in;
        end
    end

    // Valid pulse follows the capture by one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_valid <= 1'b0;
        end else begin
            rdata_valid <= cap_strobe;
        end
    end

endmodule

// File: rtl/sram_port_ctrl.sv
// Top of the static RAM access controller. Turns single-byte requests on a
// valid/ready port into asynchronous memory pin sequences. Wait-state
// counts are derived from nanosecond limits and the clock period.
// Assumes one memory device and no overlap between requests.
module sram_port_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int T_CLK_NS = 8,
    parameter int T_AA_NS  = 15,
    parameter int T_WP_NS  = 12,
    parameter int T_DS_NS  = 8,
    parameter int T_WC_NS  = 15,
    parameter int T_HZ_NS  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int RD_CYC    = imax(1, ceil_div(T_AA_NS, T_CLK_NS));
    localparam int PULSE_CYC = imax(1, imax(ceil_div(T_WP_NS, T_CLK_NS),
                                            ceil_div(T_DS_NS, T_CLK_NS)));
    localparam int REC_CYC   = imax(1, ceil_div(T_WC_NS, T_CLK_NS) - PULSE_CYC);
    localparam int HZ_CYC    = imax(1, ceil_div(T_HZ_NS, T_CLK_NS));
    localparam int MAX_CYC   = imax(imax(RD_CYC, PULSE_CYC), imax(REC_CYC, HZ_CYC));
    localparam int CNT_W     = imax(1, $clog2(MAX_CYC + 1));

    seq_state_e state_d;
    logic       accept;
    logic       cap_strobe;

    sram_seq_fsm #(
        .RD_CYC    (RD_CYC),
        .PULSE_CYC (PULSE_CYC),
        .REC_CYC   (REC_CYC),
        .HZ_CYC    (HZ_CYC),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .state_d    (state_d),
        .req_ready  (req_ready),
        .accept     (accept),
        .cap_strobe (cap_strobe)
    );

    sram_pin_drive #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_d    (state_d),
        .accept     (accept),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .mem_sel_n  (mem_sel_n),
        .mem_sel    (mem_sel),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_dq_oe  (mem_dq_oe)
    );

    sram_rd_capture #(
        .DATA_W (DATA_W)
    ) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_strobe  (cap_strobe),
        .mem_dq_in   (mem_dq_in),
        .rdata       (rdata),
        .rdata_valid (rdata_valid)
    );

endmodule

// File: rtl/sram_port_ctrl_checks.sv
// Protocol checker for the access controller, attached by bind.
// Observes top-level ports only.
module sram_port_ctrl_checks #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rdata_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_sel_n,
    input logic              mem_sel,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);

    // R2: the two selects always move as a complementary pair.
    p_sel_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel_n == !mem_sel);

    // R3: a write strobe comes with select and driver on, and output enable off.
    p_write_pins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_sel && mem_oe_n && mem_dq_oe));

    // R5: output enable low means a selected read with the driver off.
    p_read_pins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_sel && mem_we_n && !mem_dq_oe));

    // R6: read valid is a single-cycle pulse.
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |=> !rdata_valid);

    // R7: the driver stays off in the cycle after output enable was low.
    p_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!mem_oe_n) |-> !mem_dq_oe);

    // R8: an idle controller leaves the memory fully quiet.
    p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_sel && mem_we_n && mem_oe_n && !mem_dq_oe));

    // R9: address and data hold steady across a write pulse.
    p_write_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

endmodule

bind sram_port_ctrl sram_port_ctrl_checks #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rdata_valid (rdata_valid),
    .mem_addr    (mem_addr),
    .mem_sel_n   (mem_sel_n),
    .mem_sel     (mem_sel),
    .mem_we_n    (mem_we_n),
    .mem_oe_n    (mem_oe_n),
    .mem_dq_out  (mem_dq_out),
    .mem_dq_oe   (mem_dq_oe)
);

// File: tb/sram_port_ctrl_bench.sv
// Directed bench with a behavioural byte memory on the pin side.
module sram_port_ctrl_bench;

    localparam int T_CLK = 8;
    localparam int RD    = (15 + T_CLK - 1) / T_CLK;          // R5
    localparam int PULSE = (12 + T_CLK - 1) / T_CLK;          // R3, wp dominates ds
    localparam int REC   = ((15 + T_CLK - 1) / T_CLK - PULSE) < 1 ? 1
                         : ((15 + T_CLK - 1) / T_CLK - PULSE); // R4
    localparam int HZ    = (7 + T_CLK - 1) / T_CLK;           // R7

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rdata_valid;
    logic [7:0]  rdata;
    logic [16:0] mem_addr;
    logic        mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'h00;

    int checks = 0;
    int errors = 0;
    int conflicts = 0;
    int hz_left = 0;
    bit done = 0;

    logic [7:0] store [int];

    always #(T_CLK/2) clk = ~clk;

    sram_port_ctrl u_sram_port_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rdata(rdata), .rdata_valid(rdata_valid), .mem_addr(mem_addr),
        .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    // Memory model: stores on write strobe, drives the bus for reads.
    always @(posedge clk) begin
        if (!mem_sel_n && mem_sel && !mem_we_n)
            store[int'(mem_addr)] = mem_dq_out;
    end

    // Memory model: read data and bus-release window, updated mid-cycle.
    always @(negedge clk) begin
        bit drv;
        drv = !mem_sel_n && mem_sel && mem_we_n && !mem_oe_n;
        if (mem_dq_oe && (drv || hz_left > 0)) conflicts++;
        if (drv) hz_left = HZ;
        else if (hz_left > 0) hz_left--;
        if (drv) mem_dq_in = store.exists(int'(mem_addr)) ? store[int'(mem_addr)] : 8'h00;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        // R8: scramble request inputs while busy
        req_valid = 1'b0; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
    endtask

    task automatic do_write(input logic [16:0] a, input logic [7:0] d);
        issue(1'b1, a, d);
        for (int i = 0; i < PULSE; i++) begin
            if (i > 0) @(negedge clk);
            chk("R3", "we_n low", mem_we_n, 0);
            chk("R3", "oe_n high", mem_oe_n, 1);
            chk("R3", "dq_oe", mem_dq_oe, 1);
            chk("R3", "dq_out", mem_dq_out, d);
            chk("R2", "sel pair", {mem_sel_n, mem_sel}, 2'b01);
            chk("R9", "addr", mem_addr, a);
            chk("R8", "ready busy", req_ready, 0);
        end
        for (int i = 0; i < REC; i++) begin
            @(negedge clk);
            chk("R4", "rec we_n", mem_we_n, 1);
            chk("R4", "rec dq_oe", mem_dq_oe, 1);
            chk("R2", "rec deselect", {mem_sel_n, mem_sel}, 2'b10);
            chk("R4", "rec ready", req_ready, 0);
        end
        @(negedge clk);
        chk("R4", "ready back", req_ready, 1);
        chk("R4", "driver off", mem_dq_oe, 0);
    endtask

    task automatic do_read(input logic [16:0] a, input logic [7:0] exp);
        issue(1'b0, a, 8'h3C);
        for (int i = 0; i < RD; i++) begin
            if (i > 0) @(negedge clk);
            chk("R5", "oe_n low", mem_oe_n, 0);
            chk("R5", "we_n high", mem_we_n, 1);
            chk("R5", "dq_oe off", mem_dq_oe, 0);
            chk("R2", "sel pair", {mem_sel_n, mem_sel}, 2'b01);
            chk("R9", "addr", mem_addr, a);
            chk("R6", "no early valid", rdata_valid, 0);
        end
        for (int j = 1; j <= HZ; j++) begin
            @(negedge clk);
            chk("R7", "oe_n high", mem_oe_n, 1);
            chk("R7", "ready low", req_ready, 0);
            chk("R6", "valid", rdata_valid, (j == 1) ? 1 : 0);
            if (j == 1) chk("R6", "rdata", rdata, exp);
        end
        @(negedge clk);
        chk("R7", "ready back", req_ready, 1);
        chk("R6", "valid dropped", rdata_valid, 0);
        chk("R6", "rdata held", rdata, exp);
    endtask

    task automatic test_reset();
        chk("R1", "sel pair", {mem_sel_n, mem_sel}, 2'b10);
        chk("R1", "we_n", mem_we_n, 1);
        chk("R1", "oe_n", mem_oe_n, 1);
        chk("R1", "dq_oe", mem_dq_oe, 0);
        chk("R1", "valid", rdata_valid, 0);
        chk("R1", "ready", req_ready, 1);
    endtask

    task automatic test_patterns();
        do_write(17'h00000, 8'h00);
        do_write(17'h1FFFF, 8'hFF);
        do_write(17'h0AAAA, 8'hA5);
        do_write(17'h15555, 8'h5A);
        do_read(17'h00000, 8'h00);
        do_read(17'h1FFFF, 8'hFF);
        do_read(17'h0AAAA, 8'hA5);
        do_read(17'h15555, 8'h5A);
    endtask

    task automatic test_overwrite_and_turn();
        do_write(17'h00123, 8'h11);
        do_write(17'h00123, 8'hC3);
        do_read(17'h00123, 8'hC3);
        do_write(17'h00124, 8'h96);   // R7: write straight after read
        do_read(17'h00124, 8'h96);
        do_read(17'h1FFFF, 8'hFF);    // R9: top address still intact
        chk("R7", "bus conflicts", conflicts, 0);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_patterns();
        test_overwrite_and_turn();
        done = 1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
        end
    end

endmodule